// File: doc/BRIEF.md
# Core Standby and Wakeup Sequencer

This block sits beside one processor core. It takes the low-power hint requests from the instruction pipeline and runs the core's clock-gate enable. On a wait-for-interrupt or wait-for-event request it first waits for the memory system to report that no transactions are outstanding. It then drops the gate enable and holds the core in standby. The sequencer runs on the ungated clock and keeps watching the wake sources while the core is halted. When a qualifying wake source appears, the sequencer restores the clock and raises a one-cycle completion pulse, which retires the hint instruction.

The two request kinds share one sequencer but wake on different sources. Interrupt-style sources wake either kind: the interrupt lines, the fast-interrupt line, the asynchronous-abort line, and a debug request when it is allowed. These sources are taken before any interrupt masking, so a masked interrupt still ends standby. The wait-for-event kind can also wake from a one-bit pending-event flag. That flag is set by events from peer cores, by a periodic timer event, by the core's own send-event request and by a local send-event request. A send-event request is also broadcast to the other cores of the cluster.

Top module: `core_standby_ctrl`

## Requirements
- R1: After reset, `core_clk_en_o` is 1, `lp_done_o` is 0, `evt_bcast_o` is 0, and the pending-event flag is clear.
- R2: After a WFI or WFE request, `core_clk_en_o` stays 1 as long as `mem_pending_i` is nonzero. The enable drops in the cycle after the sequencer has seen `mem_pending_i` equal to zero.
- R3: In standby, any nonzero bit of `irq_i`, or a high `fiq_i` or `async_abort_i`, wakes the core. No mask takes part in this decision. `core_clk_en_o` returns to 1 and `lp_done_o` pulses in the cycle after the source is sampled.
- R4: `dbg_req_i` wakes the core only when both `dbg_invasive_i` and `dbg_permit_i` are 1. If either enable is 0, the request has no effect.
- R5: Each accepted request produces exactly one `lp_done_o` pulse, one cycle long. The sequencer then returns to its run state.
- R6: Wake sources are level-sensitive and are not stored. A source that rises and falls before the request leaves the core in standby until a new source arrives.
- R7: A wake source seen while the sequencer waits for memory to drain cancels the standby entry. Completion follows one cycle later, and `core_clk_en_o` never drops, even if `mem_pending_i` is still nonzero.
- R8: A WFE that finds the pending-event flag set clears the flag and pulses `lp_done_o` in the next cycle, without gating the clock. A WFE that finds the flag clear enters standby.
- R9: In WFE standby, a pulse on any bit of `peer_evt_i` or on `tmr_evt_i` sets the flag and wakes the core two cycles after the pulse is sampled. Interrupt-style sources also wake a WFE. A WFI is not woken by events.
- R10: `sev_req_i` makes `evt_bcast_o` high for exactly the next cycle and also sets the core's own pending-event flag.
- R11: `sevl_req_i` sets the pending-event flag without raising `evt_bcast_o`.
- R12: WFI or WFE requests that arrive while the sequencer is not in its run state are ignored. They cause no extra completion. When WFI and WFE arrive in the same cycle, WFI is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated clock; always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req_i | input | 1 | Wait-for-interrupt request pulse |
| wfe_req_i | input | 1 | Wait-for-event request pulse |
| sev_req_i | input | 1 | Send-event request pulse (broadcast) |
| sevl_req_i | input | 1 | Local send-event request pulse |
| mem_pending_i | input | CNT_W | Count of outstanding memory transactions |
| irq_i | input | IRQ_W | Raw interrupt lines, taken before masking |
| fiq_i | input | 1 | Raw fast-interrupt line |
| async_abort_i | input | 1 | Raw asynchronous-abort line |
| dbg_req_i | input | 1 | Asynchronous debug request |
| dbg_invasive_i | input | 1 | Invasive debug enabled |
| dbg_permit_i | input | 1 | Debug events permitted |
| peer_evt_i | input | PEER_W | Event pulses from other cores |
| tmr_evt_i | input | 1 | Periodic timer event pulse |
| evt_bcast_o | output | 1 | Registered event broadcast to the cluster |
| core_clk_en_o | output | 1 | Core clock-gate enable (registered) |
| lp_done_o | output | 1 | Hint instruction completion pulse |

## Verification
The bench goes after the drain hold-off first. If the gate dropped on the request itself, the clock would be stopped while memory traffic was still in flight. A design that remembered an earlier interrupt pulse would leave standby at once, where it should stay halted. The bench also checks that a wake seen during drain completes without gating; a design that got this wrong would gate the clock and then hang or un-gate too late.

The event checks cover several mistakes. A pending flag that is not cleared on use would make every following WFE complete at once. If the broadcast did not feed the sender's own flag, a WFE after SEV would sleep. A WFI that took events as wake sources would leave standby early. Requests sent during standby and debug requests without both enables are checked against the completion scoreboard, which flags any stray or extra pulse.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_STANDBY = 2'd2,
        ST_WAKE    = 2'd3
    } stby_state_e;

    typedef enum logic {
        MODE_WFI = 1'b0,
        MODE_WFE = 1'b1
    } lp_mode_e;

    typedef struct packed {
        stby_state_e state;
        lp_mode_e    mode;
        logic        clk_en;
        logic        done;
    } seq_regs_t;

    typedef struct packed {
        logic pend;
        logic bcast;
    } evt_regs_t;

endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
    parameter int IRQ_W = 2
) (
    input  logic [IRQ_W-1:0] irq_i,
    input  logic             fiq_i,
    input  logic             async_abort_i,
    input  logic             dbg_req_i,
    input  logic             dbg_invasive_i,
    input  logic             dbg_permit_i,
    output logic             intr_wake_o
);

    logic dbg_ok;
    logic exc_any;

    always_comb begin
        // Mask bits are deliberately absent: raw lines qualify directly.
        exc_any     = (|irq_i) | fiq_i | async_abort_i;
        dbg_ok      = dbg_req_i & dbg_invasive_i & dbg_permit_i;
        intr_wake_o = exc_any | dbg_ok;
    end

endmodule

// File: rtl/stby_evt_latch.sv
module stby_evt_latch
    import stby_pkg::*;
#(
    parameter int PEER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEER_W-1:0] peer_evt_i,
    input  logic              tmr_evt_i,
    input  logic              sev_i,
    input  logic              sevl_i,
    input  logic              consume_i,
    output logic              pend_o,
    output logic              bcast_o
);

    evt_regs_t evt_d, evt_q;
    logic      set_any;

    always_comb begin
        evt_d   = evt_q;
        set_any = (|peer_evt_i) | tmr_evt_i | sev_i | sevl_i;
        // A new event in the consuming cycle is kept (set wins).
        evt_d.pend  = set_any | (evt_q.pend & ~consume_i);
        evt_d.bcast = sev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign pend_o  = evt_q.pend;
    assign bcast_o = evt_q.bcast;

    assert_bcast_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sev_i |=> (bcast_o && pend_o));

    assert_local_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sevl_i && !sev_i) |=> (pend_o && !bcast_o));

endmodule

// File: rtl/stby_seq.sv
module stby_seq
    import stby_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req_i,
    input  logic             wfe_req_i,
    input  logic [CNT_W-1:0] mem_pending_i,
    input  logic             intr_wake_i,
    input  logic             evt_pend_i,
    output logic             consume_o,
    output logic             clk_en_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] MEM_IDLE = '0;

    seq_regs_t seq_d, seq_q;
    logic      wake_sel;
    logic      drained;

    always_comb begin
        seq_d     = seq_q;
        consume_o = 1'b0;
        drained   = (mem_pending_i == MEM_IDLE);
        wake_sel  = intr_wake_i | ((seq_q.mode == MODE_WFE) & evt_pend_i);
        seq_d.done = 1'b0;

        unique case (seq_q.state)
            ST_RUN: begin
                if (wfi_req_i) begin
                    seq_d.state = ST_DRAIN;
                    seq_d.mode  = MODE_WFI;
                end else if (wfe_req_i) begin
                    if (evt_pend_i) begin
                        consume_o  = 1'b1;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.state = ST_DRAIN;
                        seq_d.mode  = MODE_WFE;
                    end
                end
            end
            ST_DRAIN: begin
                if (wake_sel) begin
                    seq_d.state = ST_WAKE;
                    consume_o   = (seq_q.mode == MODE_WFE) & evt_pend_i;
                end else if (drained) begin
                    seq_d.state = ST_STANDBY;
                end
            end
            ST_STANDBY: begin
                if (wake_sel) begin
                    seq_d.state = ST_WAKE;
                    consume_o   = (seq_q.mode == MODE_WFE) & evt_pend_i;
                end
            end
            ST_WAKE: begin
                seq_d.state = ST_RUN;
            end
            default: begin
                seq_d.state = ST_RUN;
            end
        endcase

        seq_d.clk_en = (seq_d.state != ST_STANDBY);
        if (seq_d.state == ST_WAKE) begin
            seq_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state  <= ST_RUN;
            seq_q.mode   <= MODE_WFI;
            seq_q.clk_en <= 1'b1;
            seq_q.done   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign clk_en_o = seq_q.clk_en;
    assign done_o   = seq_q.done;

    assert_hold_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_DRAIN && mem_pending_i != MEM_IDLE) |=> clk_en_o);

    assert_wake_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STANDBY && intr_wake_i) |=> (clk_en_o && done_o));

    assert_wake_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_WAKE) |=> (seq_q.state == ST_RUN && !done_o));

    assert_no_memory_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STANDBY && seq_q.mode == MODE_WFI && !intr_wake_i)
        |=> (seq_q.state == ST_STANDBY && !clk_en_o));

    assert_drain_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_DRAIN && intr_wake_i) |=> (clk_en_o && done_o));

    assert_fast_wfe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && wfe_req_i && !wfi_req_i && evt_pend_i)
        |=> (done_o && seq_q.state == ST_RUN && clk_en_o));

    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STANDBY) |=> (seq_q.state != ST_DRAIN));

endmodule

// File: rtl/core_standby_ctrl.sv
module core_standby_ctrl
    import stby_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int IRQ_W  = 2,
    parameter int PEER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wfi_req_i,
    input  logic              wfe_req_i,
    input  logic              sev_req_i,
    input  logic              sevl_req_i,
    input  logic [CNT_W-1:0]  mem_pending_i,
    input  logic [IRQ_W-1:0]  irq_i,
    input  logic              fiq_i,
    input  logic              async_abort_i,
    input  logic              dbg_req_i,
    input  logic              dbg_invasive_i,
    input  logic              dbg_permit_i,
    input  logic [PEER_W-1:0] peer_evt_i,
    input  logic              tmr_evt_i,
    output logic              evt_bcast_o,
    output logic              core_clk_en_o,
    output logic              lp_done_o
);

    logic intr_wake;
    logic evt_pend;
    logic consume;

    stby_wake_qual #(.IRQ_W(IRQ_W)) u_qual (
        .irq_i          (irq_i),
        .fiq_i          (fiq_i),
        .async_abort_i  (async_abort_i),
        .dbg_req_i      (dbg_req_i),
        .dbg_invasive_i (dbg_invasive_i),
        .dbg_permit_i   (dbg_permit_i),
        .intr_wake_o    (intr_wake)
    );

    stby_evt_latch #(.PEER_W(PEER_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .peer_evt_i (peer_evt_i),
        .tmr_evt_i  (tmr_evt_i),
        .sev_i      (sev_req_i),
        .sevl_i     (sevl_req_i),
        .consume_i  (consume),
        .pend_o     (evt_pend),
        .bcast_o    (evt_bcast_o)
    );

    stby_seq #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wfi_req_i     (wfi_req_i),
        .wfe_req_i     (wfe_req_i),
        .mem_pending_i (mem_pending_i),
        .intr_wake_i   (intr_wake),
        .evt_pend_i    (evt_pend),
        .consume_o     (consume),
        .clk_en_o      (core_clk_en_o),
        .done_o        (lp_done_o)
    );

    assert_gate_drained_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en_o) |-> ($past(mem_pending_i) == '0));

    assert_dbg_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en_o && irq_i == '0 && !fiq_i && !async_abort_i && !evt_pend
         && peer_evt_i == '0 && !tmr_evt_i && !sev_req_i && !sevl_req_i
         && !(dbg_req_i && dbg_invasive_i && dbg_permit_i))
        |=> !core_clk_en_o);

endmodule

// File: tb/core_standby_ctrl_test.sv
module core_standby_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 4;
    localparam int IRQ_W  = 2;
    localparam int PEER_W = 3;
    localparam int WATCHDOG_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wfi_req = 1'b0, wfe_req = 1'b0, sev_req = 1'b0, sevl_req = 1'b0;
    logic [CNT_W-1:0]  mem_pending = '0;
    logic [IRQ_W-1:0]  irq = '0;
    logic              fiq = 1'b0, abrt = 1'b0;
    logic              dbg_req = 1'b0, dbg_inv = 1'b0, dbg_perm = 1'b0;
    logic [PEER_W-1:0] peer_evt = '0;
    logic              tmr_evt = 1'b0;
    logic              evt_bcast, clk_en, lp_done;

    int tests_run = 0;
    int tests_failed = 0;
    int cyc = 0;
    int exp_q[$];
    bit finished = 0;

    core_standby_ctrl #(.CNT_W(CNT_W), .IRQ_W(IRQ_W), .PEER_W(PEER_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wfi_req_i      (wfi_req),
        .wfe_req_i      (wfe_req),
        .sev_req_i      (sev_req),
        .sevl_req_i     (sevl_req),
        .mem_pending_i  (mem_pending),
        .irq_i          (irq),
        .fiq_i          (fiq),
        .async_abort_i  (abrt),
        .dbg_req_i      (dbg_req),
        .dbg_invasive_i (dbg_inv),
        .dbg_permit_i   (dbg_perm),
        .peer_evt_i     (peer_evt),
        .tmr_evt_i      (tmr_evt),
        .evt_bcast_o    (evt_bcast),
        .core_clk_en_o  (clk_en),
        .lp_done_o      (lp_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Driver side of the scoreboard: cycle at which a completion is due.
    task automatic expect_done(input int at_cyc);
        exp_q.push_back(at_cyc);
    endtask

    // Monitor side: each completion pulse must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && lp_done === 1'b1) begin
            tests_run++;
            if (exp_q.size() == 0) begin
                tests_failed++;
                $display("FAIL R5/R12: unexpected completion actual cycle %0d expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    tests_failed++;
                    $display("FAIL R5: completion actual cycle %0d expected %0d", cyc, e);
                end
            end
        end
    end

    task automatic enter_wfi();
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0; tick(1);
    endtask

    task automatic enter_wfe();
        wfe_req = 1'b1; tick(1); wfe_req = 1'b0; tick(1);
    endtask

    task automatic wake_irq(input string req);
        irq = 2'b01; expect_done(cyc + 1); tick(1);
        chk(req, clk_en, 1'b1);
        irq = '0; tick(2);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!finished && cyc > WATCHDOG_CYC) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG_CYC);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 clk_en", clk_en, 1'b1);
        chk("R1 done", lp_done, 1'b0);
        chk("R1 bcast", evt_bcast, 1'b0);

        // R2: gate held while memory busy, drops after count reaches zero
        mem_pending = 4'd3;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        tick(4);
        chk("R2 busy hold", clk_en, 1'b1);
        mem_pending = '0; tick(1);
        chk("R2 gated", clk_en, 1'b0);
        tick(3);
        chk("R2 still gated", clk_en, 1'b0);
        irq = 2'b10; expect_done(cyc + 1); tick(1);
        chk("R3 irq wake", clk_en, 1'b1);
        irq = '0; tick(2);

        // R3: fast interrupt and asynchronous abort
        enter_wfi();
        chk("R3 standby", clk_en, 1'b0);
        fiq = 1'b1; expect_done(cyc + 1); tick(1);
        chk("R3 fiq wake", clk_en, 1'b1);
        fiq = 1'b0; tick(2);
        enter_wfi();
        abrt = 1'b1; expect_done(cyc + 1); tick(1);
        chk("R3 abort wake", clk_en, 1'b1);
        abrt = 1'b0; tick(2);

        // R4: debug wake needs both enables
        enter_wfi();
        dbg_req = 1'b1; dbg_inv = 1'b0; dbg_perm = 1'b1; tick(3);
        chk("R4 no invasive", clk_en, 1'b0);
        dbg_inv = 1'b1; dbg_perm = 1'b0; tick(3);
        chk("R4 not permitted", clk_en, 1'b0);
        dbg_perm = 1'b1; expect_done(cyc + 1); tick(1);
        chk("R4 debug wake", clk_en, 1'b1);
        dbg_req = 1'b0; dbg_inv = 1'b0; dbg_perm = 1'b0; tick(2);

        // R6: interrupt pulse before the request is lost
        irq = 2'b01; tick(2); irq = '0; tick(2);
        enter_wfi();
        tick(4);
        chk("R6 stays in standby", clk_en, 1'b0);
        wake_irq("R6 new source wakes");

        // R7: wake during drain cancels gating, with memory still busy
        mem_pending = 4'd5;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        chk("R7 drain clk_en", clk_en, 1'b1);
        irq = 2'b01; expect_done(cyc + 1); tick(1);
        chk("R7 no gating", clk_en, 1'b1);
        irq = '0; mem_pending = '0; tick(1);
        chk("R7 after wake", clk_en, 1'b1);
        tick(2);

        // R12: requests during standby are ignored; one completion only
        enter_wfi();
        wfe_req = 1'b1; wfi_req = 1'b1; tick(1); wfe_req = 1'b0; wfi_req = 1'b0;
        tick(2);
        chk("R12 still standby", clk_en, 1'b0);
        wake_irq("R12 wake");
        tick(3);
        chk("R12 no extra gating", clk_en, 1'b1);

        // R12: simultaneous WFI and WFE -> WFI taken (event does not wake it)
        wfi_req = 1'b1; wfe_req = 1'b1; tick(1); wfi_req = 1'b0; wfe_req = 1'b0; tick(1);
        tmr_evt = 1'b1; tick(1); tmr_evt = 1'b0; tick(3);
        chk("R12 wfi priority", clk_en, 1'b0);
        wake_irq("R12 wfi wake");
        // flag left set by the timer event: consume it with a fast WFE
        wfe_req = 1'b1; expect_done(cyc + 1); tick(1); wfe_req = 1'b0;
        chk("R8 fast consume", clk_en, 1'b1);
        tick(2);

        // R8/R9: WFE with flag clear sleeps; peer event wakes two cycles later
        enter_wfe();
        chk("R8 wfe sleeps", clk_en, 1'b0);
        expect_done(cyc + 2);
        peer_evt = 3'b100; tick(1); peer_evt = '0;
        chk("R9 one cycle after event", clk_en, 1'b0);
        tick(1);
        chk("R9 peer wake", clk_en, 1'b1);
        tick(2);

        // R9: timer event wake
        enter_wfe();
        expect_done(cyc + 2);
        tmr_evt = 1'b1; tick(1); tmr_evt = 1'b0; tick(1);
        chk("R9 timer wake", clk_en, 1'b1);
        tick(2);

        // R9: interrupt also wakes a WFE
        enter_wfe();
        wake_irq("R9 irq wakes wfe");

        // R9: WFI ignores events; R8 fast WFE then clears flag
        enter_wfi();
        peer_evt = 3'b001; tick(1); peer_evt = '0; tick(3);
        chk("R9 wfi ignores event", clk_en, 1'b0);
        wake_irq("R9 wfi wake");
        wfe_req = 1'b1; expect_done(cyc + 1); tick(1); wfe_req = 1'b0;
        chk("R8 fast no gate", clk_en, 1'b1);
        tick(1);
        enter_wfe();
        chk("R8 flag cleared", clk_en, 1'b0);
        wake_irq("R8 wake");

        // R11: local send-event sets flag, no broadcast
        sevl_req = 1'b1; tick(1); sevl_req = 1'b0;
        chk("R11 no bcast", evt_bcast, 1'b0);
        wfe_req = 1'b1; expect_done(cyc + 1); tick(1); wfe_req = 1'b0;
        chk("R11 flag set", clk_en, 1'b1);
        tick(2);

        // R10: send-event broadcasts one cycle and feeds own flag
        sev_req = 1'b1; tick(1); sev_req = 1'b0;
        chk("R10 bcast high", evt_bcast, 1'b1);
        tick(1);
        chk("R10 bcast one cycle", evt_bcast, 1'b0);
        wfe_req = 1'b1; expect_done(cyc + 1); tick(1); wfe_req = 1'b0;
        chk("R10 own flag", clk_en, 1'b1);
        tick(3);

        tests_run++;
        if (exp_q.size() != 0) begin
            tests_failed++;
            $display("FAIL R5: missing completions actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule